// File: doc/BRIEF.md
# Nanosecond Time Counter with One-Shot Alarm

This block keeps a 64-bit count of elapsed nanoseconds that grows by a fixed step, `STEP_NS`, on every clock cycle. Software reaches it through a plain 32-bit register port. That port has an address, a write strobe with write data, and a read strobe with read data. Read data is registered and appears on `bus_rdata` in the cycle after the read strobe.

Software moves 64-bit values through two 32-bit halves, and each transfer stays coherent:
- Reading the low time word also latches the high time word. A later read of the high offset returns that latched copy.
- Writing the high time word only stages it. The next low-word write loads both halves into the counter at once.
- The alarm is written high word first. The low-word write arms it.

When the counter reaches or passes the alarm value, the block disarms the alarm and sets a pending flag. The pending flag drives a registered interrupt line, gated by an enable bit. Software can cancel an armed alarm and clear the pending flag.

Top module: `ns_alarm_timer`

## Requirements
- R1: After reset the counter, staged high word, held high word, alarm value, enable bit, pending flag, armed state and `irq` are all zero.
- R2: The counter grows by `STEP_NS` (default 4) on every cycle in which no low-time write happens, with carry from bit 31 into bit 32.
- R3: A read of offset 0x00 returns the live low word and latches the live high word. A read of 0x04 returns the latched high word, even if the live high word has since changed. Read data appears the cycle after `bus_re`.
- R4: A write to 0x04 changes only the staged high word and leaves the counter running. A write to 0x00 loads {staged high, written low} into the counter in one cycle. A read of 0x00 in the next cycle returns exactly the written low word.
- R5: Writes to 0x0c and 0x08 set the high and low alarm words, and both read back at those offsets. A write to 0x08 arms the alarm. Offset 0x18 reads 1 while the alarm is armed and 0 otherwise.
- R6: While armed, the alarm fires in the cycle where the full 64-bit counter is greater than or equal to the alarm value. Firing sets the pending flag and disarms the alarm, so each arming fires once.
- R7: An alarm value already below the counter fires in the cycle right after the arming write.
- R8: Writing a value with bit 0 set to offset 0x14 disarms the alarm without setting the pending flag. Writing a value with bit 0 clear there has no effect.
- R9: Bit 0 of offset 0x10 is the interrupt enable and reads back. `irq` is a register equal to (pending AND enable) one cycle late. The pending flag survives while the enable is cleared.
- R10: Writing a value with bit 0 set to offset 0x1c clears the pending flag.
- R11: Reads of 0x14, 0x1c and of offsets outside 0x00–0x1c return zero. Writes to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data, valid the cycle after `bus_re` |
| irq | output | 1 | Level interrupt: pending and enabled |

## Verification
The in-line assertions check the following properties on every cycle:
- The per-cycle step and the atomic counter load.
- Capture of the held high word on low-word reads.
- Disarming and pending set on firing, and the effect of cancel and clear.
- That a rising `irq` was preceded by pending and enable.
- Zero data for unmapped reads.

Only the bench scenarios can show the following:
- Exact firing cycles at the equality boundary and across the 32-bit word split.
- Immediate firing of an alarm already in the past.
- Staleness of the held high word after the counter carries.
- Survival of pending through masking.

// File: rtl/nstmr_pkg.sv
package nstmr_pkg;

  // Register offsets (byte addresses, word aligned). Software relies on them.
  localparam logic [4:0] OFF_TIME_LO  = 5'h00;
  localparam logic [4:0] OFF_TIME_HI  = 5'h04;
  localparam logic [4:0] OFF_ALM_LO   = 5'h08;
  localparam logic [4:0] OFF_ALM_HI   = 5'h0c;
  localparam logic [4:0] OFF_IRQ_EN   = 5'h10;
  localparam logic [4:0] OFF_CANCEL   = 5'h14;
  localparam logic [4:0] OFF_ARMED    = 5'h18;
  localparam logic [4:0] OFF_PEND_CLR = 5'h1c;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_TIME_LO,
    SEL_TIME_HI,
    SEL_ALM_LO,
    SEL_ALM_HI,
    SEL_IRQ_EN,
    SEL_CANCEL,
    SEL_ARMED,
    SEL_PEND_CLR
  } reg_sel_e;

  typedef struct packed {
    logic time_lo;
    logic time_hi;
    logic alm_lo;
    logic alm_hi;
    logic irq_en;
    logic cancel;
    logic pend_clr;
  } wr_strb_t;

endpackage

// File: rtl/nstmr_decode.sv
module nstmr_decode
  import nstmr_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic              wbit0,
  output reg_sel_e          sel,
  output wr_strb_t          strb
);

  logic in_window;

  always_comb begin
    in_window = ((addr >> 5) == '0);
    sel = SEL_NONE;
    if (in_window) begin
      case (addr[4:0])
        OFF_TIME_LO:  sel = SEL_TIME_LO;
        OFF_TIME_HI:  sel = SEL_TIME_HI;
        OFF_ALM_LO:   sel = SEL_ALM_LO;
        OFF_ALM_HI:   sel = SEL_ALM_HI;
        OFF_IRQ_EN:   sel = SEL_IRQ_EN;
        OFF_CANCEL:   sel = SEL_CANCEL;
        OFF_ARMED:    sel = SEL_ARMED;
        OFF_PEND_CLR: sel = SEL_PEND_CLR;
        default:      sel = SEL_NONE;
      endcase
    end
  end

  always_comb begin
    strb          = '0;
    strb.time_lo  = we && (sel == SEL_TIME_LO);
    strb.time_hi  = we && (sel == SEL_TIME_HI);
    strb.alm_lo   = we && (sel == SEL_ALM_LO);
    strb.alm_hi   = we && (sel == SEL_ALM_HI);
    strb.irq_en   = we && (sel == SEL_IRQ_EN);
    strb.cancel   = we && (sel == SEL_CANCEL) && wbit0;
    strb.pend_clr = we && (sel == SEL_PEND_CLR) && wbit0;
  end

endmodule

// File: rtl/nstmr_counter.sv
module nstmr_counter #(
  parameter int TIME_W  = 64,
  parameter int STEP_NS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                stage_we,
  input  logic                load_we,
  input  logic [TIME_W/2-1:0] wdata,
  output logic [TIME_W-1:0]   cnt
);

  localparam int                WORD_W = TIME_W / 2;
  localparam logic [TIME_W-1:0] STEP   = TIME_W'(STEP_NS);

  logic [WORD_W-1:0] stage_q;
  logic [TIME_W-1:0] cnt_q;

  // Staged high word: touched only by high-word writes.
  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
    end else if (stage_we) begin
      stage_q <= wdata;
    end
  end

  // Time counter: both halves load together, otherwise it steps.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_we) begin
      cnt_q <= {stage_q, wdata};
    end else begin
      cnt_q <= cnt_q + STEP;
    end
  end

  assign cnt = cnt_q;

  // R2: free-running step
  a_r2_step : assert property (@(posedge clk) disable iff (rst)
    !load_we |=> cnt_q == $past(cnt_q) + STEP);

  // R4: atomic 64-bit load from staged high and written low
  a_r4_atomic_load : assert property (@(posedge clk) disable iff (rst)
    load_we |=> cnt_q == {$past(stage_q), $past(wdata)});

endmodule

// File: rtl/nstmr_alarm.sv
module nstmr_alarm #(
  parameter int TIME_W = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [TIME_W-1:0]   cnt,
  input  logic                alm_hi_we,
  input  logic                alm_lo_we,
  input  logic                cancel_we,
  input  logic                pend_clr_we,
  input  logic                ien_we,
  input  logic [TIME_W/2-1:0] wdata,
  output logic [TIME_W-1:0]   cmp,
  output logic                armed,
  output logic                ien,
  output logic                irq
);

  localparam int WORD_W = TIME_W / 2;

  logic [WORD_W-1:0] cmp_hi_q, cmp_lo_q;
  logic              armed_q, pend_q, ien_q, irq_q;
  logic              reached, fire;

  assign cmp     = {cmp_hi_q, cmp_lo_q};
  assign reached = (cnt >= cmp);
  assign fire    = armed_q && reached;

  // Alarm compare words.
  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_hi_q <= '0;
      cmp_lo_q <= '0;
    end else begin
      if (alm_hi_we) cmp_hi_q <= wdata;
      if (alm_lo_we) cmp_lo_q <= wdata;
    end
  end

  // Armed state: a low-word write arms; cancel or firing disarms.
  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
    end else if (alm_lo_we) begin
      armed_q <= 1'b1;
    end else if (cancel_we || fire) begin
      armed_q <= 1'b0;
    end
  end

  // Pending flag: set by a firing that is not cancelled the same cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
    end else if (fire && !cancel_we) begin
      pend_q <= 1'b1;
    end else if (pend_clr_we) begin
      pend_q <= 1'b0;
    end
  end

  // Enable bit and registered interrupt line.
  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (ien_we) ien_q <= wdata[0];
      irq_q <= pend_q && ien_q;
    end
  end

  assign armed = armed_q;
  assign ien   = ien_q;
  assign irq   = irq_q;

  // R6: firing disarms and raises pending
  a_r6_fire_disarms : assert property (@(posedge clk) disable iff (rst)
    fire && !alm_lo_we |=> !armed_q);
  a_r6_fire_pends : assert property (@(posedge clk) disable iff (rst)
    fire && !cancel_we |=> pend_q);

  // R8: cancel disarms without creating a pending flag
  a_r8_cancel : assert property (@(posedge clk) disable iff (rst)
    cancel_we && !alm_lo_we |=> !armed_q && (pend_q == $past(pend_q && !pend_clr_we)));

  // R9: the interrupt rises only after pending and enable were both set
  a_r9_irq_source : assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> $past(pend_q && ien_q));

  // R10: clear removes pending when nothing fires
  a_r10_clear : assert property (@(posedge clk) disable iff (rst)
    pend_clr_we && !fire |=> !pend_q);

endmodule

// File: rtl/nstmr_rdmux.sv
module nstmr_rdmux
  import nstmr_pkg::*;
#(
  parameter int TIME_W = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                re,
  input  reg_sel_e            sel,
  input  logic [TIME_W-1:0]   cnt,
  input  logic [TIME_W-1:0]   cmp,
  input  logic                armed,
  input  logic                ien,
  output logic [TIME_W/2-1:0] rdata
);

  localparam int WORD_W = TIME_W / 2;

  logic [WORD_W-1:0] hold_q, rdata_q, rd_next;

  always_comb begin
    case (sel)
      SEL_TIME_LO: rd_next = cnt[WORD_W-1:0];
      SEL_TIME_HI: rd_next = hold_q;
      SEL_ALM_LO:  rd_next = cmp[WORD_W-1:0];
      SEL_ALM_HI:  rd_next = cmp[TIME_W-1:WORD_W];
      SEL_IRQ_EN:  rd_next = WORD_W'(ien);
      SEL_ARMED:   rd_next = WORD_W'(armed);
      default:     rd_next = '0;
    endcase
  end

  // High word latched by every low-word read.
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
    end else if (re && (sel == SEL_TIME_LO)) begin
      hold_q <= cnt[TIME_W-1:WORD_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (re) begin
      rdata_q <= rd_next;
    end
  end

  assign rdata = rdata_q;

  // R3: low-word read captures the live high word
  a_r3_hold : assert property (@(posedge clk) disable iff (rst)
    re && (sel == SEL_TIME_LO) |=> hold_q == $past(cnt[TIME_W-1:WORD_W]));

  // R11: unmapped and write-only offsets read as zero
  a_r11_zero_read : assert property (@(posedge clk) disable iff (rst)
    re && (sel == SEL_NONE || sel == SEL_CANCEL || sel == SEL_PEND_CLR) |=> rdata_q == '0);

endmodule

// File: rtl/ns_alarm_timer.sv
module ns_alarm_timer
  import nstmr_pkg::*;
#(
  parameter int TIME_W  = 64,
  parameter int ADDR_W  = 6,
  parameter int STEP_NS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [TIME_W/2-1:0] bus_wdata,
  input  logic                bus_re,
  output logic [TIME_W/2-1:0] bus_rdata,
  output logic                irq
);

  reg_sel_e          sel;
  wr_strb_t          strb;
  logic [TIME_W-1:0] cnt, cmp;
  logic              armed, ien;

  nstmr_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr  (bus_addr),
    .we    (bus_we),
    .wbit0 (bus_wdata[0]),
    .sel   (sel),
    .strb  (strb)
  );

  nstmr_counter #(.TIME_W(TIME_W), .STEP_NS(STEP_NS)) u_counter (
    .clk      (clk),
    .rst      (rst),
    .stage_we (strb.time_hi),
    .load_we  (strb.time_lo),
    .wdata    (bus_wdata),
    .cnt      (cnt)
  );

  nstmr_alarm #(.TIME_W(TIME_W)) u_alarm (
    .clk         (clk),
    .rst         (rst),
    .cnt         (cnt),
    .alm_hi_we   (strb.alm_hi),
    .alm_lo_we   (strb.alm_lo),
    .cancel_we   (strb.cancel),
    .pend_clr_we (strb.pend_clr),
    .ien_we      (strb.irq_en),
    .wdata       (bus_wdata),
    .cmp         (cmp),
    .armed       (armed),
    .ien         (ien),
    .irq         (irq)
  );

  nstmr_rdmux #(.TIME_W(TIME_W)) u_rdmux (
    .clk   (clk),
    .rst   (rst),
    .re    (bus_re),
    .sel   (sel),
    .cnt   (cnt),
    .cmp   (cmp),
    .armed (armed),
    .ien   (ien),
    .rdata (bus_rdata)
  );

endmodule

// File: tb/tb_ns_alarm_timer.sv
module tb_ns_alarm_timer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq;
  logic [31:0] rv;
  int          checks = 0;
  int          failures = 0;

  always #2 clk = ~clk;  // 250 MHz

  ns_alarm_timer dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata), .irq(irq)
  );

  // {is_read, offset, data/expected}
  localparam logic [40:0] VEC [16] = '{
    {1'b0, 8'h0c, 32'h1234_5678},  // R5 alarm high
    {1'b0, 8'h08, 32'h9abc_def0},  // R5 alarm low, arms
    {1'b1, 8'h0c, 32'h1234_5678},  // R5
    {1'b1, 8'h08, 32'h9abc_def0},  // R5
    {1'b1, 8'h18, 32'h0000_0001},  // R5 armed
    {1'b0, 8'h14, 32'h0000_0001},  // R8 cancel
    {1'b1, 8'h18, 32'h0000_0000},  // R8
    {1'b1, 8'h14, 32'h0000_0000},  // R11
    {1'b1, 8'h1c, 32'h0000_0000},  // R11
    {1'b1, 8'h24, 32'h0000_0000},  // R11
    {1'b0, 8'h10, 32'h0000_0001},  // R9 enable
    {1'b1, 8'h10, 32'h0000_0001},  // R9
    {1'b0, 8'h10, 32'h0000_0000},  // R9 disable
    {1'b1, 8'h10, 32'h0000_0000},  // R9
    {1'b0, 8'h2c, 32'hffff_ffff},  // R11 unmapped write
    {1'b1, 8'h08, 32'h9abc_def0}   // R11 nothing changed
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Every task starts and ends at a falling edge and spans one rising edge.
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a[5:0]; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    bus_addr = a[5:0]; bus_re = 1'b1;
    @(posedge clk);
    @(negedge clk);
    v = bus_rdata;
    bus_re = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd(8'h00, rv); chk("R1 time low", rv, 32'h0);
    rd(8'h18, rv); chk("R1 armed", rv, 32'h0);
    rd(8'h0c, rv); chk("R1 alarm high", rv, 32'h0);

    // Vector table
    for (int i = 0; i < 16; i++) begin
      if (VEC[i][40]) begin
        rd(VEC[i][39:32], rv);
        chk($sformatf("vector %0d (R5/R8/R9/R11)", i), rv, VEC[i][31:0]);
      end else begin
        wr(VEC[i][39:32], VEC[i][31:0]);
      end
    end
    chk("R11 irq after unmapped write", {31'b0, irq}, 32'h0);

    // R2 carry across the word split
    wr(8'h04, 32'd5); wr(8'h00, 32'hffff_fff8);
    idle(2);
    rd(8'h00, rv); chk("R2 carry low", rv, 32'h0);
    rd(8'h04, rv); chk("R2 carry high", rv, 32'd6);

    // R3 held high word goes stale, R4 exact load
    wr(8'h04, 32'd7); wr(8'h00, 32'hffff_fff0);
    rd(8'h00, rv); chk("R4 load low", rv, 32'hffff_fff0);
    idle(10);
    rd(8'h04, rv); chk("R3 stale hold", rv, 32'd7);
    rd(8'h00, rv); chk("R3 low after wait", rv, 32'h0000_0020);
    rd(8'h04, rv); chk("R3 new hold", rv, 32'd8);

    // R4 staging only
    wr(8'h04, 32'h0); wr(8'h00, 32'h100); wr(8'h04, 32'haaaa);
    rd(8'h00, rv); chk("R4 running after stage", rv, 32'h104);
    rd(8'h04, rv); chk("R4 high untouched", rv, 32'h0);

    // R6 fire at equality boundary
    wr(8'h10, 32'h1);
    wr(8'h04, 32'h0); wr(8'h00, 32'd1000);
    wr(8'h0c, 32'h0); wr(8'h08, 32'd1100);
    rd(8'h18, rv); chk("R5 armed", rv, 32'h1);
    chk("R6 irq early", {31'b0, irq}, 32'h0);
    idle(22);
    chk("R6 irq before match", {31'b0, irq}, 32'h0);
    idle(2);
    chk("R6 irq at match", {31'b0, irq}, 32'h1);
    rd(8'h18, rv); chk("R6 disarmed", rv, 32'h0);

    // R9 masking keeps pending
    wr(8'h10, 32'h0); idle(1);
    chk("R9 masked", {31'b0, irq}, 32'h0);
    wr(8'h10, 32'h1); idle(1);
    chk("R9 pending kept", {31'b0, irq}, 32'h1);

    // R10 clear, R6 once only
    wr(8'h1c, 32'h1); idle(1);
    chk("R10 cleared", {31'b0, irq}, 32'h0);
    idle(5);
    chk("R6 no refire", {31'b0, irq}, 32'h0);

    // R7 past alarm
    wr(8'h04, 32'h0); wr(8'h00, 32'd5000);
    wr(8'h0c, 32'h0); wr(8'h08, 32'd100);
    idle(2);
    chk("R7 immediate fire", {31'b0, irq}, 32'h1);
    wr(8'h1c, 32'h1); idle(1);

    // R8 cancel
    wr(8'h04, 32'h0); wr(8'h00, 32'h0);
    wr(8'h0c, 32'h0); wr(8'h08, 32'd200);
    wr(8'h14, 32'h1);
    rd(8'h18, rv); chk("R8 cancelled", rv, 32'h0);
    idle(80);
    chk("R8 no fire", {31'b0, irq}, 32'h0);
    wr(8'h08, 32'h0001_0000);
    wr(8'h14, 32'h0);
    rd(8'h18, rv); chk("R8 bit0 clear ignored", rv, 32'h1);
    wr(8'h14, 32'h1);

    // R6 full 64-bit compare
    wr(8'h04, 32'h0); wr(8'h00, 32'hffff_ff00);
    wr(8'h0c, 32'h1); wr(8'h08, 32'h0);
    idle(20);
    chk("R6 high word blocks", {31'b0, irq}, 32'h0);
    idle(60);
    chk("R6 high word fire", {31'b0, irq}, 32'h1);

    // R1 reset from busy state
    wr(8'h08, 32'hffff_ffff);
    rst = 1'b1; idle(2); rst = 1'b0;
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
    rd(8'h00, rv); chk("R1 counter", rv, 32'h0);
    rd(8'h04, rv); chk("R1 hold", rv, 32'h0);
    rd(8'h08, rv); chk("R1 alarm low", rv, 32'h0);
    rd(8'h10, rv); chk("R1 enable", rv, 32'h0);
    rd(8'h18, rv); chk("R1 armed after reset", rv, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule